// File: doc/BRIEF.md
# ADC Conversion Sequencer with Register Interface

This block lets software run an eight-channel, ten-bit converter core through a small set of word registers. Software chooses a channel and the single-conversion mode, then sets a start bit. The block forwards that request to the core as a one-cycle start pulse. When the core reports completion, the block captures the result and the channel it belongs to in the same cycle and raises a completion flag.

Power is also under register control. The converter comes out of reset powered down. After software writes the power-down bit to zero, the block counts a settling window of converter clock cycles. No start pulse reaches the core before that window has closed. A start requested while the converter is down or still settling is kept pending and goes out as soon as the window ends. Software confirms ownership of a result by reading the sampled-channel register before it reads the data register.

Top module: `adc_ctrl_top`

## Requirements
- R1: The config word (offset 0x00) holds the channel in bits [2:0], the start request in bit 4 and the single-conversion mode in bit 5, and reads back as written. The start bit clears itself on the edge that issues the conversion to the core.
- R2: A read of offset 0x04 returns the latest captured ten-bit result in bits [9:0], with bits [31:10] zero.
- R3: Bit 0 of offset 0x08 becomes 1 when a completed result is captured. It returns to 0 on the edge of any config write that has bit 4 set.
- R4: Bits [2:0] of offset 0x0C return the channel that was issued with the conversion whose result is currently held. It is captured in the same cycle as the result.
- R5: Bit 0 of offset 0x10 drives the core power-down output. It is 1 after reset, and while it is 1 no start pulse is issued.
- R6: After the power-down bit is written from 1 to 0, the start output stays low for SETTLE_CYC (default 6) cycles. A request already pending is issued as a one-cycle pulse that is visible SETTLE_CYC+1 edges after the power-up write.
- R7: A start request made while the converter is down or settling is held, not dropped, and completes once the window expires.
- R8: Reads of unmapped offsets return zero, and writes to them change no register.
- R9: Offset 0x20 returns the number of results captured since reset.
- R10: Offset 0x14 returns, for debugging, core ready in bit 0, conversion in flight in bit 1 and start pending in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| core_pwr_dn | output | 1 | Power-down level to the converter core |
| core_start | output | 1 | One-cycle conversion start pulse |
| core_chan | output | 3 | Channel issued with the start pulse |
| core_done | input | 1 | Core reports that a conversion has finished |
| core_result | input | 10 | Conversion result, valid with core_done |

## Verification
The main conversion path runs over a table of channel and result pairs. The table includes all-zeros, all-ones, alternating bit patterns and single set bits, so that swapped or dropped result bits and channel bits show up as different values. Separate directed cases target the timing. One issues a start while powered down and measures the exact edge of the first pulse against the settling window. Another clears the completion flag with a new start, and a third writes to unmapped offsets to show that nothing changes.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam logic [5:0] OFF_CFG  = 6'h00;
  localparam logic [5:0] OFF_DATA = 6'h04;
  localparam logic [5:0] OFF_EOC  = 6'h08;
  localparam logic [5:0] OFF_SMP  = 6'h0C;
  localparam logic [5:0] OFF_PWR  = 6'h10;
  localparam logic [5:0] OFF_DBG  = 6'h14;
  localparam logic [5:0] OFF_CNT  = 6'h20;
  localparam int BIT_START  = 4;
  localparam int BIT_SINGLE = 5;
endpackage

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int SETTLE_CYC = 6,
  localparam int SW = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_wr_en,
  input  logic pd_wr_val,
  output logic pwr_dn,
  output logic ready
);
  logic [SW-1:0] settle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_dn   <= 1'b1;
      settle_q <= '0;
    end else if (pd_wr_en && pd_wr_val) begin
      pwr_dn   <= 1'b1;
      settle_q <= '0;
    end else if (pd_wr_en && pwr_dn) begin
      pwr_dn   <= 1'b0;
      settle_q <= '0;
    end else if (!pwr_dn && settle_q != SW'(SETTLE_CYC)) begin
      settle_q <= settle_q + 1'b1;
    end
  end

  assign ready = !pwr_dn && (settle_q == SW'(SETTLE_CYC));
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int CH_W  = 3,
  parameter int RES_W = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ready,
  input  logic             start_pend,
  input  logic [CH_W-1:0]  chan_in,
  input  logic             clr_eoc,
  input  logic             core_done,
  input  logic [RES_W-1:0] core_result,
  output logic             issue,
  output logic             core_start,
  output logic [CH_W-1:0]  core_chan,
  output logic             busy,
  output logic             eoc,
  output logic [RES_W-1:0] result,
  output logic [CH_W-1:0]  smp_chan,
  output logic [CNT_W-1:0] done_cnt
);
  logic capture;

  assign issue   = start_pend && ready && !busy;
  assign capture = busy && ready && core_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_start <= 1'b0;
      core_chan  <= '0;
      busy       <= 1'b0;
      eoc        <= 1'b0;
      result     <= '0;
      smp_chan   <= '0;
      done_cnt   <= '0;
    end else begin
      core_start <= issue;
      if (issue) begin
        core_chan <= chan_in;
        busy      <= 1'b1;
      end else if (!ready) begin
        busy <= 1'b0;
      end
      if (capture) begin
        busy     <= 1'b0;
        result   <= core_result;
        smp_chan <= core_chan;
        eoc      <= 1'b1;
        done_cnt <= done_cnt + 1'b1;
      end
      if (clr_eoc) eoc <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_regbank.sv
module adc_regbank
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int CH_W   = 3,
  parameter int RES_W  = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              issue,
  input  logic              pwr_dn,
  input  logic              ready,
  input  logic              busy,
  input  logic              eoc,
  input  logic [RES_W-1:0]  result,
  input  logic [CH_W-1:0]   smp_chan,
  input  logic [CNT_W-1:0]  done_cnt,
  output logic              pd_wr_en,
  output logic              pd_wr_val,
  output logic              clr_eoc,
  output logic [CH_W-1:0]   cfg_chan,
  output logic              start_pend
);
  logic cfg_single;
  logic cfg_wr;
  logic [DATA_W-1:0] rd_mux;

  assign cfg_wr    = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_CFG));
  assign pd_wr_en  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_PWR));
  assign pd_wr_val = bus_wdata[0];
  assign clr_eoc   = cfg_wr && bus_wdata[BIT_START];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_chan   <= '0;
      cfg_single <= 1'b0;
      start_pend <= 1'b0;
    end else begin
      if (issue) start_pend <= 1'b0;
      if (cfg_wr) begin
        cfg_chan   <= bus_wdata[CH_W-1:0];
        cfg_single <= bus_wdata[BIT_SINGLE];
        start_pend <= bus_wdata[BIT_START];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFF_CFG): begin
        rd_mux[CH_W-1:0]   = cfg_chan;
        rd_mux[BIT_START]  = start_pend;
        rd_mux[BIT_SINGLE] = cfg_single;
      end
      ADDR_W'(OFF_DATA): rd_mux[RES_W-1:0] = result;
      ADDR_W'(OFF_EOC):  rd_mux[0] = eoc;
      ADDR_W'(OFF_SMP):  rd_mux[CH_W-1:0] = smp_chan;
      ADDR_W'(OFF_PWR):  rd_mux[0] = pwr_dn;
      ADDR_W'(OFF_DBG):  rd_mux[2:0] = {start_pend, busy, ready};
      ADDR_W'(OFF_CNT):  rd_mux[CNT_W-1:0] = done_cnt;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/adc_ctrl_top.sv
module adc_ctrl_top #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 6,
  parameter int NUM_CH     = 8,
  parameter int RES_W      = 10,
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 6,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              core_pwr_dn,
  output logic              core_start,
  output logic [CH_W-1:0]   core_chan,
  input  logic              core_done,
  input  logic [RES_W-1:0]  core_result
);
  logic pd_wr_en, pd_wr_val, pwr_dn, ready;
  logic clr_eoc, start_pend, issue, busy, eoc;
  logic [CH_W-1:0]  cfg_chan, smp_chan;
  logic [RES_W-1:0] result;
  logic [CNT_W-1:0] done_cnt;

  adc_pwr_seq #(.SETTLE_CYC(SETTLE_CYC)) u_pwr (
    .clk(clk), .rst(rst), .pd_wr_en(pd_wr_en), .pd_wr_val(pd_wr_val),
    .pwr_dn(pwr_dn), .ready(ready)
  );

  adc_conv_seq #(.CH_W(CH_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_conv (
    .clk(clk), .rst(rst), .ready(ready), .start_pend(start_pend),
    .chan_in(cfg_chan), .clr_eoc(clr_eoc), .core_done(core_done),
    .core_result(core_result), .issue(issue), .core_start(core_start),
    .core_chan(core_chan), .busy(busy), .eoc(eoc), .result(result),
    .smp_chan(smp_chan), .done_cnt(done_cnt)
  );

  adc_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CH_W(CH_W),
                .RES_W(RES_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .issue(issue), .pwr_dn(pwr_dn), .ready(ready), .busy(busy), .eoc(eoc),
    .result(result), .smp_chan(smp_chan), .done_cnt(done_cnt),
    .pd_wr_en(pd_wr_en), .pd_wr_val(pd_wr_val), .clr_eoc(clr_eoc),
    .cfg_chan(cfg_chan), .start_pend(start_pend)
  );

  assign core_pwr_dn = pwr_dn;
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int CH_W       = 3,
  parameter int RES_W      = 10,
  parameter int SETTLE_CYC = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              core_pwr_dn,
  input logic              core_start,
  input logic              core_done,
  input logic              busy,
  input logic              ready,
  input logic              eoc,
  input logic              clr_eoc,
  input logic [CH_W-1:0]   cfg_chan
);
  int unsigned up_cnt;
  logic unmapped;

  always_ff @(posedge clk) begin
    if (rst || core_pwr_dn) up_cnt <= 0;
    else if (up_cnt < SETTLE_CYC + 2) up_cnt <= up_cnt + 1;
  end

  assign unmapped = !(bus_addr inside {6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h20});

  // R6
  settle_gap_chk: assert property (@(posedge clk) disable iff (rst)
    core_start |-> (up_cnt > SETTLE_CYC));
  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    core_start |=> !core_start);
  // R5
  no_start_when_down_chk: assert property (@(posedge clk) disable iff (rst)
    core_pwr_dn |-> !core_start);
  // R3
  eoc_set_chk: assert property (@(posedge clk) disable iff (rst)
    (core_done && busy && ready && !clr_eoc) |=> eoc);
  // R3
  eoc_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_eoc |=> !eoc);
  // R2
  data_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == 6'h04) |=> (bus_rdata[DATA_W-1:RES_W] == '0));
  // R8
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && unmapped) |=> $stable(cfg_chan));
endmodule

bind adc_ctrl_top adc_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W), .RES_W(RES_W),
  .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .core_pwr_dn(core_pwr_dn),
  .core_start(core_start), .core_done(core_done), .busy(busy),
  .ready(ready), .eoc(eoc), .clr_eoc(clr_eoc), .cfg_chan(cfg_chan)
);

// File: tb/sim_adc_ctrl_top.sv
module sim_adc_ctrl_top;
  localparam int SETTLE = 6;
  localparam int LAT    = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel, bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        core_pwr_dn, core_start, core_done;
  logic [2:0]  core_chan;
  logic [9:0]  core_result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int start_cyc = -1;
  int start_seen = 0;
  logic [9:0] stub_val;
  int lat_q;

  always #5 clk = ~clk;

  adc_ctrl_top u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_pwr_dn(core_pwr_dn), .core_start(core_start),
    .core_chan(core_chan), .core_done(core_done), .core_result(core_result)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (core_start) begin
      start_seen <= start_seen + 1;
      if (start_cyc < 0) start_cyc <= cyc;
    end

  // Behavioural converter: fixed latency after each start pulse
  always @(posedge clk) begin
    if (rst) begin
      lat_q <= 0; core_done <= 1'b0; core_result <= '0;
    end else begin
      core_done <= 1'b0;
      if (core_start) lat_q <= LAT;
      else if (lat_q > 0) begin
        lat_q <= lat_q - 1;
        if (lat_q == 1) begin core_done <= 1'b1; core_result <= stub_val; end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_eoc(output logic [31:0] d);
    d = 0;
    for (int i = 0; i < 60 && d[0] !== 1'b1; i++) rd(6'h08, d);
  endtask

  // channel, result
  localparam logic [12:0] VEC [0:5] = '{
    {3'd0, 10'h000}, {3'd7, 10'h3FF}, {3'd3, 10'h155},
    {3'd5, 10'h2AA}, {3'd1, 10'h001}, {3'd6, 10'h200}
  };

  task automatic run_all();
    logic [31:0] d;
    int pu_cyc;
    int n;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; stub_val = 10'h123;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // reset state
    chk("R5 reset pwr_dn port", {31'd0, core_pwr_dn}, 32'd1);
    rd(6'h10, d); chk("R5 reset power reg", d, 32'd1);
    rd(6'h08, d); chk("R3 reset eoc", d, 32'd0);
    rd(6'h04, d); chk("R2 reset data", d, 32'd0);
    rd(6'h20, d); chk("R9 reset count", d, 32'd0);

    // start while powered down is held
    wr(6'h00, 32'h32);
    repeat (10) @(negedge clk);
    chk("R5 no start while down", start_seen, 0);
    rd(6'h14, d); chk("R10 debug pending, not ready", d, 32'h4);
    rd(6'h00, d); chk("R7 start bit held", d, 32'h32);
    wr(6'h10, 32'h0);
    pu_cyc = cyc;
    wait_eoc(d);
    chk("R7 held request completes", d, 32'd1);
    chk("R6 first start edge after window", start_cyc - pu_cyc, SETTLE + 1);
    rd(6'h0C, d); chk("R4 sampled channel", d, 32'd2);
    rd(6'h04, d); chk("R2 result", d, 32'h123);
    rd(6'h00, d); chk("R1 start self-cleared", d, 32'h22);
    rd(6'h14, d); chk("R10 debug ready idle", d, 32'h1);
    n = 1;

    // table walk
    foreach (VEC[i]) begin
      stub_val = VEC[i][9:0];
      wr(6'h00, {26'd0, 1'b1, 2'b00, VEC[i][12:10]});
      rd(6'h00, d); chk("R1 config readback", d, {26'd0, 1'b1, 2'b00, VEC[i][12:10]});
      wr(6'h00, d | 32'h10);
      wait_eoc(d);
      chk("R3 eoc set", d, 32'd1);
      n++;
      rd(6'h0C, d); chk("R4 sampled channel", d, {29'd0, VEC[i][12:10]});
      rd(6'h04, d); chk("R2 result zero-extended", d, {22'd0, VEC[i][9:0]});
      rd(6'h00, d); chk("R1 start self-cleared", d, {26'd0, 1'b1, 2'b00, VEC[i][12:10]});
    end

    // new start clears completion flag
    stub_val = 10'h0F0;
    wr(6'h00, 32'h34);
    rd(6'h08, d); chk("R3 eoc cleared by start", d, 32'd0);
    wait_eoc(d); n++;
    rd(6'h0C, d); chk("R4 sampled channel 4", d, 32'd4);
    rd(6'h20, d); chk("R9 completion count", d, n);

    // unmapped offsets
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h00, d); chk("R8 config untouched", d, 32'h24);
    rd(6'h18, d); chk("R8 unmapped read 0x18", d, 32'd0);
    rd(6'h3C, d); chk("R8 unmapped read 0x3C", d, 32'd0);
    chk("R8 no spurious start", start_seen, n);

    // power down again
    wr(6'h10, 32'h1);
    rd(6'h10, d); chk("R5 power reg down", d, 32'd1);
    chk("R5 pwr_dn port down", {31'd0, core_pwr_dn}, 32'd1);
    rd(6'h14, d); chk("R10 debug not ready", d, 32'd0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule